// File: doc/BRIEF.md
# Masked Vector Lane Execution Unit

This block runs a single element-wise vector operation over a vector register of up to N elements, one element per clock. A length register, loaded with each operation, limits how many leading elements take part. An internal mask register, one bit per element, chooses which results are written back. Arithmetic operations read two operands per element through a register read port and return results through a write port. Compare operations write their per-element outcome into the mask, and a mask-invert operation flips every mask bit. A two-way select can therefore be done as two masked writes with an invert between them.

Arithmetic operations run in one of two modes. In full mode the unit visits every element below the length in ascending order. Each result is offered with a write enable equal to that element's mask bit. In density-time mode the unit visits only the elements whose mask bit is set, so disabled elements take no cycles.

The write port is valid/ready. A result stays offered, with index, data and enable held, until the consumer accepts it, and the unit does not advance while `wr_ready` is low. Control (`start`, `busy`, `done`) is plain level/pulse signalling.

Top module: `vlane_exec`

## Requirements
- R1: After reset `busy`, `done` and `wr_valid` are 0 and every mask bit is 1.
- R2: `start` is taken only while `busy` is 0. A `start` pulse during an operation has no effect on that operation's results or on the mask.
- R3: Opcodes: 0 add, 1 subtract, 2 multiply (low EW bits of the product), 3 logical shift right of operand A by one. Each result is a function of the two operands read at `rd_idx` equal to the element index. The mask does not change while an arithmetic operation runs.
- R4: Full mode (`dense` = 0) offers every element i below the length in ascending order, with `wr_en` equal to mask bit i.
- R5: Density-time mode (`dense` = 1) offers only elements below the length whose mask bit is 1, in ascending order, with `wr_en` = 1. With `wr_ready` held high, `done` comes k+1 cycles after the cycle in which `start` was taken, where k is the number of such elements.
- R6: A `vlen` above N is treated as N.
- R7: For an arithmetic operation whose length is 0, or with no mask bit set below the length, `done` pulses in the cycle after `start` is taken and `wr_valid` never rises. This holds in either mode.
- R8: Opcodes 4, 5 and 6 set mask bit i, for each i below the length, to (A[i] == 0), (A[i] != 0) and signed (A[i] >= B[i]) respectively. Mask bits at or above the length are kept. No write is offered, and `done` follows length+1 cycles after `start`.
- R9: Opcode 7 inverts all N mask bits, and `done` pulses in the next cycle.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_idx`, `wr_data` and `wr_en` hold their values into the next cycle.
- R11: `done` is a one-cycle pulse in the cycle after the last element is accepted. `busy` is 1 from the cycle after `start` through the `done` cycle and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 3 | Opcode, see R3, R8, R9 |
| dense | input | 1 | 1 = density-time mode, 0 = full mode |
| vlen | input | $clog2(N+1) | Number of leading elements to process |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | output | $clog2(N) | Element index for the operand read port |
| rd_a | input | EW | Operand A of element `rd_idx` |
| rd_b | input | EW | Operand B of element `rd_idx` |
| wr_valid | output | 1 | A result is offered |
| wr_ready | input | 1 | Consumer accepts the offered result |
| wr_idx | output | $clog2(N) | Destination element index |
| wr_data | output | EW | Result value |
| wr_en | output | 1 | Write enable for this element |
| mask_out | output | N | Current mask register |

## Verification
On every cycle, the assertions check the following. The held offer under back-pressure. The single-cycle `done` pulse followed by idle. Strictly rising element indices within an operation. Indices staying below the length. A set enable on every density-time offer. A mask frozen during arithmetic. The bench's reference model must show everything that depends on data and ordering as a whole. That covers the per-opcode result values, which elements a full or density-time pass visits, and the exact completion cycle counts. It also covers the clamping of an oversized length, empty passes, how compares and inversion change the mask, and an ignored `start` during a run.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_SHR  = 3'd3,
    OP_CEQZ = 3'd4,
    OP_CNEZ = 3'd5,
    OP_CGE  = 3'd6,
    OP_MINV = 3'd7
  } vop_e;

  function automatic logic op_is_cmp(vop_e o);
    return (o == OP_CEQZ) || (o == OP_CNEZ) || (o == OP_CGE);
  endfunction
endpackage

// File: rtl/vlane_alu.sv
module vlane_alu
  import vlane_pkg::*;
#(
  parameter int EW = 16
) (
  input  vop_e          op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] res,
  output logic          cond
);
  logic [2*EW-1:0] prod;

  assign prod = a * b;

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = prod[EW-1:0];
      OP_SHR:  res = a >> 1;
      default: res = '0;
    endcase
  end

  always_comb begin
    case (op)
      OP_CEQZ: cond = (a == '0);
      OP_CNEZ: cond = (a != '0);
      OP_CGE:  cond = ($signed(a) >= $signed(b));
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/vlane_mask.sv
module vlane_mask #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic          wbit,
  output logic [N-1:0]  mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (inv) begin
      mask <= ~mask;
    end else if (we) begin
      mask[widx] <= wbit;
    end
  end
endmodule

// File: rtl/vlane_seq.sv
module vlane_seq
  import vlane_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int LW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  vop_e          op_in,
  input  logic          dense_in,
  input  logic [LW-1:0] vlen_in,
  input  logic [N-1:0]  mask,
  input  logic          wr_ready,
  output logic          busy,
  output logic          done,
  output logic          issue,
  output logic          cmp_we,
  output logic          inv,
  output vop_e          op_cur,
  output logic [IW-1:0] idx
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

  st_e           st;
  vop_e          op_q;
  logic          dense_q;
  logic [LW-1:0] len_q;
  logic [IW-1:0] idx_q;

  logic [LW-1:0] len_c;
  logic [N-1:0]  act_in, en_in, en_q;
  logic          any_in;
  logic [IW:0]   first_in, nxt;
  logic          step;

  function automatic logic [IW:0] first_from(logic [N-1:0] v, int from);
    logic [IW:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i] && (i >= from)) r = {1'b1, IW'(i)};
    end
    return r;
  endfunction

  assign len_c = (vlen_in > LW'(N)) ? LW'(N) : vlen_in;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign act_in[g] = (LW'(g) < len_c);
    assign en_in[g]  = act_in[g] & (op_is_cmp(op_in) | ~dense_in | mask[g]);
    assign en_q[g]   = (LW'(g) < len_q) & (op_is_cmp(op_q) | ~dense_q | mask[g]);
  end

  assign any_in   = op_is_cmp(op_in) ? (|act_in) : (|(act_in & mask));
  assign first_in = first_from(en_in, 0);
  assign nxt      = first_from(en_q, int'(idx_q) + 1);
  assign step     = (st == S_RUN) && (op_is_cmp(op_q) || wr_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_ADD;
      dense_q <= 1'b0;
      len_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            op_q    <= op_in;
            dense_q <= dense_in;
            len_q   <= len_c;
            idx_q   <= first_in[IW-1:0];
            if (op_in == OP_MINV || !any_in) st <= S_FIN;
            else                             st <= S_RUN;
          end
        end
        S_RUN: begin
          if (step) begin
            if (nxt[IW]) idx_q <= nxt[IW-1:0];
            else         st    <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_FIN);
  assign issue  = (st == S_RUN) && !op_is_cmp(op_q);
  assign cmp_we = (st == S_RUN) && op_is_cmp(op_q);
  assign inv    = (st == S_IDLE) && start && (op_in == OP_MINV);
  assign op_cur = op_q;
  assign idx    = idx_q;

  // R4
  idx_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && nxt[IW]) |=> (idx_q > $past(idx_q)));

  // R6
  idx_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> (LW'(idx_q) < len_q));

  // R5
  dense_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dense_q) |-> mask[idx_q]);

  // R3
  mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_RUN) && !op_is_cmp(op_q)) |=> $stable(mask));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

// File: rtl/vlane_exec.sv
module vlane_exec
  import vlane_pkg::*;
#(
  parameter int N  = 8,
  parameter int EW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int LW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic          dense,
  input  logic [LW-1:0] vlen,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] rd_idx,
  input  logic [EW-1:0] rd_a,
  input  logic [EW-1:0] rd_b,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [IW-1:0] wr_idx,
  output logic [EW-1:0] wr_data,
  output logic          wr_en,
  output logic [N-1:0]  mask_out
);
  logic [N-1:0]  mask_q;
  logic          issue, cmp_we, inv, cond;
  logic [IW-1:0] idx;
  vop_e          op_cur;
  logic [EW-1:0] res;

  vlane_seq #(.N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(vop_e'(op)),
    .dense_in(dense), .vlen_in(vlen), .mask(mask_q), .wr_ready(wr_ready),
    .busy(busy), .done(done), .issue(issue), .cmp_we(cmp_we), .inv(inv),
    .op_cur(op_cur), .idx(idx)
  );

  vlane_alu #(.EW(EW)) u_alu (
    .op(op_cur), .a(rd_a), .b(rd_b), .res(res), .cond(cond)
  );

  vlane_mask #(.N(N)) u_mask (
    .clk(clk), .rst_n(rst_n), .inv(inv), .we(cmp_we), .widx(idx),
    .wbit(cond), .mask(mask_q)
  );

  assign rd_idx   = idx;
  assign wr_valid = issue;
  assign wr_idx   = idx;
  assign wr_data  = res;
  assign wr_en    = mask_q[idx];
  assign mask_out = mask_q;

  // R10
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_idx) && $stable(wr_data) && $stable(wr_en)));

  // R2
  no_offer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);
endmodule

// File: tb/test_vlane_exec.sv
module test_vlane_exec;
  localparam int N  = 8;
  localparam int EW = 16;
  localparam int IW = 3;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    op_i = '0;
  logic          dense_i = 1'b0;
  logic [LW-1:0] vlen_i = '0;
  logic          busy, done, wr_valid, wr_en;
  logic          wr_ready = 1'b0;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [EW-1:0] rd_a, rd_b, wr_data;
  logic [N-1:0]  mask_out;

  logic [EW-1:0] va [N];
  logic [EW-1:0] vb [N];
  logic [N-1:0]  mref;

  int n_cmp = 0;
  int n_bad = 0;

  int          q_idx [$];
  logic [EW-1:0] q_dat [$];
  logic        q_en  [$];

  always #2.5 clk = ~clk;

  assign rd_a = va[rd_idx];
  assign rd_b = vb[rd_idx];

  vlane_exec #(.N(N), .EW(EW)) i_vlane_exec (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .dense(dense_i),
    .vlen(vlen_i), .busy(busy), .done(done), .rd_idx(rd_idx), .rd_a(rd_a),
    .rd_b(rd_b), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_en(wr_en), .mask_out(mask_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] ref_alu(int o, logic [EW-1:0] a, logic [EW-1:0] b);
    logic [2*EW-1:0] p;
    p = a * b;
    case (o)
      0: return a + b;
      1: return a - b;
      2: return p[EW-1:0];
      3: return a >> 1;
      default: return '0;
    endcase
  endfunction

  task automatic run_op(input int o, input bit dn, input int vl, input int stall,
                        input bit poke, input string req);
    int vc, n, exp_cyc, cyc;
    logic [N-1:0] mnew;
    vc = (vl > N) ? N : vl;
    mnew = mref;
    q_idx.delete(); q_dat.delete(); q_en.delete();
    if (o <= 3) begin
      n = 0;
      for (int i = 0; i < vc; i++) if (mref[i]) n++;
      if (n > 0) begin
        for (int i = 0; i < vc; i++) begin
          if (!dn || mref[i]) begin
            q_idx.push_back(i);
            q_dat.push_back(ref_alu(o, va[i], vb[i]));
            q_en.push_back(mref[i]);
          end
        end
      end
      exp_cyc = q_idx.size() + 1;
    end else if (o == 7) begin
      mnew = ~mref;
      exp_cyc = 1;
    end else begin
      for (int i = 0; i < vc; i++) begin
        if (o == 4) mnew[i] = (va[i] == 0);
        else if (o == 5) mnew[i] = (va[i] != 0);
        else mnew[i] = ($signed(va[i]) >= $signed(vb[i]));
      end
      exp_cyc = vc + 1;
    end
    @(negedge clk);
    start = 1'b1; op_i = 3'(o); dense_i = dn; vlen_i = LW'(vl);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin
      chk(busy == 1'b1, {req, " R11 busy"}, busy, 1);
      if (wr_valid) begin
        if (q_idx.size() == 0) begin
          chk(1'b0, {req, " unexpected offer"}, wr_idx, 0);
        end else begin
          chk(wr_idx == IW'(q_idx[0]), {req, " idx"}, wr_idx, q_idx[0]);
          chk(wr_data == q_dat[0], {req, " data"}, wr_data, q_dat[0]);
          chk(wr_en == q_en[0], {req, " en"}, wr_en, q_en[0]);
        end
      end
      wr_ready = (stall == 0) ? 1'b1 : (($urandom % 100) >= stall);
      if (wr_valid && wr_ready && q_idx.size() > 0) begin
        void'(q_idx.pop_front()); void'(q_dat.pop_front()); void'(q_en.pop_front());
      end
      if (poke && cyc == 2) begin
        start = 1'b1; op_i = 3'd7; dense_i = ~dn; vlen_i = '0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, {req, " R11 done seen"}, done, 1);
    chk(q_idx.size() == 0, {req, " all offered"}, q_idx.size(), 0);
    if (stall == 0) chk(cyc == exp_cyc, {req, " cycles"}, cyc, exp_cyc);
    chk(mask_out == mnew, {req, " mask"}, mask_out, mnew);
    chk(wr_valid == 1'b0, {req, " no offer at done"}, wr_valid, 0);
    mref = mnew;
    @(negedge clk);
    chk(!done && !busy, {req, " R11 idle after done"}, {done, busy}, 0);
  endtask

  task automatic fill_rand();
    for (int i = 0; i < N; i++) begin
      va[i] = EW'($urandom);
      vb[i] = EW'($urandom);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mref = '1;
    fill_rand();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && wr_valid == 0, "R1 controls", {busy, done, wr_valid}, 0);
    chk(mask_out == '1, "R1 mask", mask_out, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 all opcodes, full mode, mask all ones
    for (int o = 0; o < 4; o++) begin
      fill_rand();
      run_op(o, 1'b0, 8, 0, 1'b0, "R3 R4 full op");
    end

    // R8 signed greater-or-equal compare builds a mask
    va[0] = 16'd3;      vb[0] = 16'd5;
    va[1] = 16'd9;      vb[1] = 16'd9;
    va[2] = 16'hFFF0;   vb[2] = 16'h0002;
    va[3] = 16'h0004;   vb[3] = 16'hFFFF;
    va[4] = 16'h8000;   vb[4] = 16'h7FFF;
    va[5] = 16'd0;      vb[5] = 16'hFFFE;
    va[6] = 16'd100;    vb[6] = 16'd99;
    va[7] = 16'hFFFE;   vb[7] = 16'hFFFF;
    run_op(6, 1'b0, 8, 0, 1'b0, "R8 cge");

    // R4 full mode with mixed mask: disabled elements offered with wr_en 0
    fill_rand();
    run_op(0, 1'b0, 8, 0, 1'b0, "R4 full masked add");
    // R5 density-time skips disabled elements
    run_op(2, 1'b1, 8, 0, 1'b0, "R5 dense mul");
    // R9 invert, then other half via dense subtract
    run_op(7, 1'b0, 0, 0, 1'b0, "R9 invert");
    run_op(1, 1'b1, 8, 0, 1'b0, "R5 dense sub after invert");
    run_op(3, 1'b1, 5, 0, 1'b0, "R5 dense shr short length");

    // R8 equal-zero on first three elements only, others kept
    va[0] = 0; va[1] = 16'd7; va[2] = 0;
    run_op(4, 1'b0, 3, 0, 1'b0, "R8 ceqz len3");
    fill_rand();
    for (int i = 0; i < N; i++) if (va[i] == 0) va[i] = 16'd1;
    va[5] = 0;
    run_op(5, 1'b1, 8, 0, 1'b0, "R8 cnez");

    // R6 oversized length clamps to N
    run_op(0, 1'b0, 12, 0, 1'b0, "R6 clamp full");
    run_op(0, 1'b1, 15, 0, 1'b0, "R6 clamp dense");
    run_op(5, 1'b0, 9, 0, 1'b0, "R6 clamp cmp");

    // R7 zero length
    run_op(0, 1'b0, 0, 0, 1'b0, "R7 len0 full");
    run_op(2, 1'b1, 0, 0, 1'b0, "R7 len0 dense");
    run_op(4, 1'b0, 0, 0, 1'b0, "R7 len0 cmp");
    // R7 all-zero mask
    for (int i = 0; i < N; i++) va[i] = 16'd3;
    run_op(4, 1'b0, 8, 0, 1'b0, "R7 clear mask");
    run_op(0, 1'b0, 8, 0, 1'b0, "R7 empty full");
    run_op(0, 1'b1, 8, 0, 1'b0, "R7 empty dense");
    // R7 mask set only above length
    run_op(7, 1'b0, 0, 0, 1'b0, "R9 invert to ones");
    va[0] = 16'd1; va[1] = 16'd1; va[2] = 0;
    run_op(4, 1'b0, 2, 0, 1'b0, "R8 clear low two");
    run_op(1, 1'b1, 2, 0, 1'b0, "R7 enabled only above length");

    // R10 back-pressure
    fill_rand();
    run_op(5, 1'b0, 8, 0, 1'b0, "R8 reload");
    run_op(0, 1'b0, 8, 50, 1'b0, "R10 stall full");
    va[1] = 0; va[4] = 0;
    run_op(4, 1'b0, 8, 0, 1'b0, "R8 sparse");
    run_op(2, 1'b1, 8, 60, 1'b0, "R10 stall dense");

    // R2 start during a run is ignored
    fill_rand();
    run_op(0, 1'b0, 8, 0, 1'b1, "R2 ignored start full");
    run_op(3, 1'b1, 8, 0, 1'b1, "R2 ignored start dense");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule